// File: doc/BRIEF.md
# Supervisor Watchdog and Reset Sequencer

This block is a small digital supervisor that drives the reset lines of a processor. Two sources can put the processor into reset: a supply-low flag, which comes from an analog comparator outside the block, and a watchdog. The watchdog expects activity on its input. If that input holds one level for too long, the watchdog fires. Either source produces a reset pulse with a fixed, parameterised width. While the supply is low the pulse is held, and it is timed from the moment the supply recovers.

All durations are counted in prescaled ticks: one tick every `TICK_DIV` clocks. After any reset ends, the watchdog's first period is always the long one. Later periods follow a select input, which chooses the short or the long period. The watchdog fault output is separate from reset. It drops when the watchdog times out, rises again on the next edge of the watchdog input, and is held inactive while the supply is low or the watchdog is disabled. A low-line output mirrors the supply-low flag, one clock late and with no stretching.

Top module: `supv_wdog_top`

## Requirements
- R1: While `supply_low` is 1, `rst_n_out` is 0 from the next clock on. After `supply_low` returns to 0, `rst_n_out` stays 0 for `PULSE_TICKS` ticks (within one tick) and then rises.
- R2: If `wd_en` is 1 and the watchdog period expires, `rst_n_out` goes low one clock after the expiry. It stays low for the same `PULSE_TICKS`-tick width.
- R3: A rising or a falling edge on `wd_in`, after a two-flop synchroniser, restarts the watchdog count. Edges spaced closer than the period never cause a reset.
- R4: While `wd_en` is 0 the watchdog count is held at zero, `wd_fault_n` is 1 and the watchdog causes no reset.
- R5: After the first period, `wd_long_sel`=1 selects a period of `LONG_TICKS` ticks and `wd_long_sel`=0 selects a period of `SHORT_TICKS` ticks.
- R6: The first watchdog period after any reset pulse ends is `LONG_TICKS`, whatever `wd_long_sel` is.
- R7: `wd_fault_n` goes to 0 in the clock where the watchdog expires, which is one clock before `rst_n_out` falls. It returns to 1 on the next synchronised edge of `wd_in`.
- R8: `wd_fault_n` is 1 whenever `low_line_n` is 0.
- R9: `low_line_n` equals the inverse of `supply_low`, delayed by one clock, with no stretching.
- R10: `rst_out` is always the exact complement of `rst_n_out`.
- R11: The watchdog count is held at zero while reset is asserted. If the supply goes low during a pulse started by the watchdog, the pulse restarts and ends `PULSE_TICKS` ticks after the supply recovers.
- R12: During the synchronous reset `rst`, `rst_n_out` is 0, `wd_fault_n` is 1 and `low_line_n` is 1. After `rst` is released, a full reset pulse follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| supply_low | input | 1 | Supply-low flag from the comparator |
| wd_in | input | 1 | Watchdog activity input (asynchronous) |
| wd_en | input | 1 | Watchdog enable (0 stands for a floating or mid-level input) |
| wd_long_sel | input | 1 | 1 selects the long period, 0 the short period |
| rst_n_out | output | 1 | Active-low processor reset |
| rst_out | output | 1 | Active-high processor reset |
| wd_fault_n | output | 1 | Active-low watchdog fault |
| low_line_n | output | 1 | Active-low supply-low indication |

## Verification
The assertions check, on every clock, the relations that hold at the ports from one cycle to the next:
- the two reset outputs are complements of each other;
- low-line follows the supply flag;
- reset is forced on a supply-low condition;
- the fault output is masked by low-line and by disable;
- a falling fault is followed by reset.

The durations need the bench's scenarios to show them: the long first period after a pulse, the short and long periods after an edge, the pulse width, and the restart of a watchdog pulse by a supply dip. Those scenarios also show that steady toggling never resets the processor, and that a fault is cleared by the next edge.

// File: rtl/supv_pkg.sv
package supv_pkg;

  // state of the reset pulse sequencer
  typedef enum logic {
    SEQ_RELEASED = 1'b0,
    SEQ_HOLDING  = 1'b1
  } seq_state_e;

  // width of a counter that holds 0 .. max_val-1
  function automatic int cnt_width(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val);
  endfunction

endpackage

// File: rtl/supv_tick_gen.sv
module supv_tick_gen #(
  parameter int TICK_DIV = 1000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_passthru
      // every clock is a tick
      always_ff @(posedge clk) begin
        if (rst) tick <= 1'b0;
        else     tick <= 1'b1;
      end
    end else begin : g_div
      localparam int CW = supv_pkg::cnt_width(TICK_DIV);
      localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
      logic [CW-1:0] div_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          div_q <= '0;
          tick  <= 1'b0;
        end else begin
          tick  <= (div_q == LAST);
          div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/supv_edge_sync.sv
module supv_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic edge_pulse
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= 1'b0;
    else     chain_q[0] <= din;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain_q[i] <= 1'b0;
        else     chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign level      = chain_q[STAGES-1];
  assign edge_pulse = chain_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/supv_wd_timer.sv
module supv_wd_timer #(
  parameter int SHORT_TICKS = 100,
  parameter int LONG_TICKS  = 1600
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic edge_pulse,
  input  logic enable,
  input  logic long_sel,
  input  logic hold,
  input  logic supply_low,
  output logic timeout,
  output logic fault_n
);
  localparam int MAXT = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
  localparam int WW   = supv_pkg::cnt_width(MAXT);
  localparam logic [WW-1:0] LONG_LAST  = WW'(LONG_TICKS - 1);
  localparam logic [WW-1:0] SHORT_LAST = WW'(SHORT_TICKS - 1);

  logic [WW-1:0] cnt_q;
  logic          first_q;
  logic [WW-1:0] last_cnt;
  logic          expire;

  // the first period after a reset pulse is always the long one
  assign last_cnt = (first_q || long_sel) ? LONG_LAST : SHORT_LAST;
  assign expire   = !hold && enable && !edge_pulse && tick && (cnt_q == last_cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      first_q <= 1'b1;
    end else if (hold) begin
      cnt_q   <= '0;
      first_q <= 1'b1;
    end else if (!enable) begin
      cnt_q   <= '0;
    end else if (edge_pulse) begin
      cnt_q   <= '0;
      first_q <= 1'b0;
    end else if (tick) begin
      cnt_q   <= expire ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      timeout <= 1'b0;
      fault_n <= 1'b1;
    end else begin
      timeout <= expire;
      if (supply_low || !enable || edge_pulse) fault_n <= 1'b1;
      else if (expire)                         fault_n <= 1'b0;
    end
  end
endmodule

// File: rtl/supv_rst_seq.sv
module supv_rst_seq #(
  parameter int PULSE_TICKS = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic supply_low,
  input  logic wd_timeout,
  output logic rst_q,
  output logic rst_n_q,
  output logic low_line_n
);
  import supv_pkg::*;

  localparam int PW = cnt_width(PULSE_TICKS);
  localparam logic [PW-1:0] PULSE_LAST = PW'(PULSE_TICKS - 1);

  seq_state_e    state_q, state_d;
  logic [PW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (supply_low) begin
      // held and re-armed for as long as the supply is low
      state_d = SEQ_HOLDING;
      cnt_d   = '0;
    end else begin
      case (state_q)
        SEQ_RELEASED: begin
          if (wd_timeout) begin
            state_d = SEQ_HOLDING;
            cnt_d   = '0;
          end
        end
        SEQ_HOLDING: begin
          if (tick) begin
            if (cnt_q == PULSE_LAST) begin
              state_d = SEQ_RELEASED;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        default: begin
          state_d = SEQ_HOLDING;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= SEQ_HOLDING;
      cnt_q      <= '0;
      rst_q      <= 1'b1;
      rst_n_q    <= 1'b0;
      low_line_n <= 1'b1;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      rst_q      <= (state_d == SEQ_HOLDING);
      rst_n_q    <= (state_d != SEQ_HOLDING);
      low_line_n <= !supply_low;
    end
  end
endmodule

// File: rtl/supv_wdog_top.sv
module supv_wdog_top #(
  parameter int TICK_DIV    = 1000,
  parameter int PULSE_TICKS = 50,
  parameter int SHORT_TICKS = 100,
  parameter int LONG_TICKS  = 1600,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_low,
  input  logic wd_in,
  input  logic wd_en,
  input  logic wd_long_sel,
  output logic rst_n_out,
  output logic rst_out,
  output logic wd_fault_n,
  output logic low_line_n
);
  logic tick;
  logic wd_level;
  logic wd_edge;
  logic wd_timeout;
  logic rst_active;

  supv_tick_gen #(.TICK_DIV(TICK_DIV)) tick_i (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  supv_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk        (clk),
    .rst        (rst),
    .din        (wd_in),
    .level      (wd_level),
    .edge_pulse (wd_edge)
  );

  supv_wd_timer #(.SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS)) wdt_i (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .edge_pulse (wd_edge),
    .enable     (wd_en),
    .long_sel   (wd_long_sel),
    .hold       (rst_active),
    .supply_low (supply_low),
    .timeout    (wd_timeout),
    .fault_n    (wd_fault_n)
  );

  supv_rst_seq #(.PULSE_TICKS(PULSE_TICKS)) seq_i (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .supply_low (supply_low),
    .wd_timeout (wd_timeout),
    .rst_q      (rst_active),
    .rst_n_q    (rst_n_out),
    .low_line_n (low_line_n)
  );

  assign rst_out = rst_active;

  logic unused_level;
  assign unused_level = wd_level;
endmodule

// File: rtl/supv_wdog_chk.sv
module supv_wdog_chk (
  input logic clk,
  input logic rst,
  input logic supply_low,
  input logic wd_en,
  input logic rst_n_out,
  input logic rst_out,
  input logic wd_fault_n,
  input logic low_line_n
);
  // R10
  complement_chk: assert property (@(posedge clk) disable iff (rst)
    rst_out == !rst_n_out);

  // R1
  supply_hold_chk: assert property (@(posedge clk) disable iff (rst)
    supply_low |=> !rst_n_out);

  // R9
  low_line_set_chk: assert property (@(posedge clk) disable iff (rst)
    supply_low |=> !low_line_n);

  // R9
  low_line_clr_chk: assert property (@(posedge clk) disable iff (rst)
    !supply_low |=> low_line_n);

  // R8
  fault_mask_chk: assert property (@(posedge clk) disable iff (rst)
    !low_line_n |-> wd_fault_n);

  // R4
  disabled_fault_chk: assert property (@(posedge clk) disable iff (rst)
    !wd_en |=> wd_fault_n);

  // R7
  fault_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wd_fault_n) |=> !rst_n_out);

  // R12
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!rst_n_out && wd_fault_n && low_line_n));
endmodule

bind supv_wdog_top supv_wdog_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .supply_low (supply_low),
  .wd_en      (wd_en),
  .rst_n_out  (rst_n_out),
  .rst_out    (rst_out),
  .wd_fault_n (wd_fault_n),
  .low_line_n (low_line_n)
);

// File: tb/supv_wdog_top_tb_top.sv
`timescale 1ns/1ps
module supv_wdog_top_tb_top;
  localparam int DIV   = 2;
  localparam int PULSE = 5;
  localparam int SHORT = 6;
  localparam int LONG  = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_low = 1'b0;
  logic wd_in = 1'b0;
  logic wd_en = 1'b0;
  logic wd_long_sel = 1'b0;
  logic rst_n_out, rst_out, wd_fault_n, low_line_n;

  int n_chk = 0;
  int n_fail = 0;
  int rst_falls = 0;
  string phase = "R12 power-on";
  logic prev_rst_n = 1'b0;

  always #2.5 clk = ~clk;

  supv_wdog_top #(
    .TICK_DIV(DIV), .PULSE_TICKS(PULSE), .SHORT_TICKS(SHORT),
    .LONG_TICKS(LONG), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rst(rst), .supply_low(supply_low), .wd_in(wd_in),
    .wd_en(wd_en), .wd_long_sel(wd_long_sel), .rst_n_out(rst_n_out),
    .rst_out(rst_out), .wd_fault_n(wd_fault_n), .low_line_n(low_line_n)
  );

  // behavioural reference, evaluated once per rising edge
  int m_s1, m_s2, m_s3, m_pc, m_tick, m_rst, m_rcnt;
  int m_wcnt, m_first, m_fault, m_to, m_ll;
  initial begin
    m_s1 = 0; m_s2 = 0; m_s3 = 0; m_pc = 0; m_tick = 0; m_rst = 1; m_rcnt = 0;
    m_wcnt = 0; m_first = 1; m_fault = 1; m_to = 0; m_ll = 1;
  end

  always @(posedge clk) begin
    int o_edge, o_tick, o_to, o_rst, lim, fire;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_pc = 0; m_tick = 0; m_rst = 1; m_rcnt = 0;
      m_wcnt = 0; m_first = 1; m_fault = 1; m_to = 0; m_ll = 1;
    end else begin
      o_edge = (m_s2 != m_s3) ? 1 : 0;
      o_tick = m_tick; o_to = m_to; o_rst = m_rst;
      lim = (m_first != 0 || wd_long_sel) ? LONG : SHORT;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = wd_in ? 1 : 0;
      m_tick = (m_pc == DIV - 1) ? 1 : 0;
      m_pc = (m_pc == DIV - 1) ? 0 : m_pc + 1;
      if (supply_low) begin
        m_rst = 1; m_rcnt = 0;
      end else if (o_rst == 0 && o_to != 0) begin
        m_rst = 1; m_rcnt = 0;
      end else if (o_rst != 0 && o_tick != 0) begin
        if (m_rcnt == PULSE - 1) begin m_rst = 0; m_rcnt = 0; end
        else m_rcnt = m_rcnt + 1;
      end
      m_ll = supply_low ? 0 : 1;
      fire = 0;
      if (o_rst != 0) begin m_wcnt = 0; m_first = 1; end
      else if (!wd_en) m_wcnt = 0;
      else if (o_edge != 0) begin m_wcnt = 0; m_first = 0; end
      else if (o_tick != 0) begin
        if (m_wcnt == lim - 1) begin m_wcnt = 0; fire = 1; end
        else m_wcnt = m_wcnt + 1;
      end
      m_to = fire;
      if (supply_low || !wd_en || o_edge != 0) m_fault = 1;
      else if (fire != 0) m_fault = 0;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic check_range(input string tag, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  // per-cycle comparison against the reference, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check({phase, " R1/R2 rst_n_out"}, rst_n_out, (m_rst == 0));
      check({phase, " R10 rst_out"}, rst_out, !rst_n_out);
      check({phase, " R7 wd_fault_n"}, wd_fault_n, (m_fault != 0));
      check({phase, " R9 low_line_n"}, low_line_n, (m_ll != 0));
      if (prev_rst_n && !rst_n_out) rst_falls++;
    end
    prev_rst_n = rst_n_out;
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_rst(input logic lvl, input int limit, output int cyc);
    cyc = 0;
    while (rst_n_out !== lvl && cyc < limit) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    int c, base;
    cycles(4);
    check("R12 reset rst_n_out", rst_n_out, 1'b0);
    check("R12 reset wd_fault_n", wd_fault_n, 1'b1);
    check("R12 reset low_line_n", low_line_n, 1'b1);
    rst = 1'b0;
    wait_rst(1'b1, 100, c);
    check_range("R12 power-on pulse width", c, (PULSE - 1) * DIV, PULSE * DIV + 3);

    // R4: watchdog disabled
    phase = "R4 disabled";
    base = rst_falls;
    cycles(200);
    check_range("R4 no reset while disabled", rst_falls - base, 0, 0);
    check("R4 fault high while disabled", wd_fault_n, 1'b1);

    // R3: steady toggling, both edge directions
    phase = "R3 toggling";
    wd_en = 1'b1; wd_long_sel = 1'b0;
    base = rst_falls;
    for (int i = 0; i < 20; i++) begin
      wd_in = ~wd_in;
      cycles(8);
    end
    check_range("R3 no reset with edges", rst_falls - base, 0, 0);

    // R5 short period, R2 pulse width, R7 fault low
    phase = "R5 short";
    wd_in = ~wd_in;
    cycles(1);
    wait_rst(1'b0, 200, c);
    check_range("R5 short period from edge", c + 1, (SHORT - 1) * DIV, SHORT * DIV + 6);
    check("R7 fault low after timeout", wd_fault_n, 1'b0);
    phase = "R2 pulse";
    wait_rst(1'b1, 200, c);
    check_range("R2 watchdog pulse width", c, (PULSE - 1) * DIV, PULSE * DIV + 3);

    // R6: first period long despite short select
    phase = "R6 first long";
    wait_rst(1'b0, 200, c);
    check_range("R6 first period is long", c, (LONG - 1) * DIV, LONG * DIV + 4);
    wait_rst(1'b1, 200, c);

    // R7: next edge clears the fault
    phase = "R7 clear";
    check("R7 fault still low before edge", wd_fault_n, 1'b0);
    wd_in = ~wd_in;
    cycles(4);
    check("R7 fault cleared by edge", wd_fault_n, 1'b1);

    // R5 long select
    phase = "R5 long";
    wd_long_sel = 1'b1;
    cycles(4);
    wd_in = ~wd_in;
    cycles(1);
    wait_rst(1'b0, 200, c);
    check_range("R5 long period from edge", c + 1, (LONG - 1) * DIV, LONG * DIV + 8);

    // R11: supply dip during a watchdog pulse
    phase = "R11 dip";
    cycles(2);
    supply_low = 1'b1;
    cycles(1);
    check("R9 low_line_n follows flag", low_line_n, 1'b0);
    check("R8 fault forced high", wd_fault_n, 1'b1);
    cycles(29);
    check("R1 reset held while low", rst_n_out, 1'b0);
    supply_low = 1'b0;
    cycles(1);
    check("R9 low_line_n releases at once", low_line_n, 1'b1);
    wait_rst(1'b1, 200, c);
    check_range("R11 pulse timed from recovery", c + 1, (PULSE - 1) * DIV, PULSE * DIV + 3);

    // R1: supply low while the watchdog is idle
    phase = "R1 supply";
    wd_en = 1'b0;
    cycles(10);
    supply_low = 1'b1;
    cycles(1);
    check("R1 reset on supply low", rst_n_out, 1'b0);
    check("R10 complement during supply low", rst_out, 1'b1);
    cycles(5);
    supply_low = 1'b0;
    cycles(1);
    wait_rst(1'b1, 200, c);
    check_range("R1 stretch after recovery", c + 1, (PULSE - 1) * DIV, PULSE * DIV + 3);
    cycles(10);
    summary();
  end
endmodule